// File: doc/BRIEF.md
# Host Interrupt Controller with Dual Status Views

This block gathers one-cycle event pulses from up to sixteen on-chip sources into a vector of latched status bits. It drives a single interrupt line toward the host. A host processor reaches it over a simple register bus that has an address, a write strobe with write data, and a read strobe with registered read data.

The host can see pending events in two ways. One register shows the pending bits and leaves them unchanged. A second register shows the same bits and clears all of them as part of the read. Single bits are retired by writing ones to an acknowledge register.

The block also holds a mask. The host can load the whole mask in one write. It can also change single mask bits atomically through a set alias and a clear alias, so it never needs a read-modify-write. An enable bit gates the interrupt line, and a configuration input selects whether the line is active high or active low.

Source slots by convention:

| Slot | Source |
|------|--------|
| 0 | receive buffer A data |
| 1 | transmit data |
| 2 | transmit transfer |
| 3 | receive buffer B data |
| 4 | receive transfer |
| 5, 6 | event mailbox |
| 7 | wake |
| 8, 9 | trace |
| 10 | command complete |
| 14 | initialization complete |

Register map, by word address on `bus_addr_i`:

| Address | Register | Access |
|---------|----------|--------|
| 0 | mask | read/write |
| 1 | mask set alias | write |
| 2 | mask clear alias | write |
| 3 | status, nondestructive | read |
| 4 | status, clear on read | read |
| 5 | acknowledge | write |
| 6 | control, bit 0 is the enable | read/write |

Top module: `hic_top`

## Requirements
- R1: When reset is released, the mask reads 0x0001, both status views read 0, the control register reads 0 (enable off) and `host_irq_o` sits at its idle level.
- R2: A write to address 0 loads the mask from the low 16 data bits, and a read of address 0 returns the mask.
- R3: A write to address 1 sets every mask bit that is written as 1 and leaves every mask bit written as 0 unchanged.
- R4: A write to address 2 clears every mask bit that is written as 1 and leaves every mask bit written as 0 unchanged.
- R5: A one-cycle pulse on `src_pulse_i[n]` sets status bit n. A read of address 3 returns the status in bits [15:0] and leaves the status unchanged.
- R6: A read of address 4 returns the status as it stood before the read, and then clears every status bit.
- R7: A write to address 5 clears each status bit that is written as 1, and both status views show the change. Bits written as 0 have no effect.
- R8: A source pulse that arrives in the same cycle as a clear-on-read or an acknowledge of the same bit wins, and the bit stays set.
- R9: With the enable (address 6, bit 0) set, the line is asserted when any status bit is set and its mask bit is 0. A set mask bit blocks that source. With the enable clear, the line stays idle.
- R10: With `cfg_active_low_i` at 0 the line is active high. With it at 1 the line is active low and idles high.
- R11: Read data appears on `bus_rdata_o` at the first clock edge after the read strobe and holds until the next read. Addresses 1, 2, 5 and 7 read as 0.
- R12: Writes to the status addresses 3 and 4 are ignored and leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_pulse_i | input | NSRC (16) | One-cycle event pulses, one per source |
| bus_addr_i | input | 3 | Register word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | DW (32) | Registered read data |
| cfg_active_low_i | input | 1 | 1 selects an active-low interrupt line |
| host_irq_o | output | 1 | Interrupt line to the host |

## Verification
A pulse or a register write takes effect at the next clock edge. The interrupt line follows the registered state with no further delay, so it is sampled just after that edge. Read data is registered at the edge that samples the read strobe, which is also the edge at which a clear-on-read takes effect. The bench therefore drives each stimulus at the falling edge and checks one nanosecond after the next rising edge. A status view read in the following vector therefore always sees every earlier side effect, and never the one from its own cycle.

// File: rtl/hic_pkg.sv
package hic_pkg;

    localparam int HIC_AW = 3;

    // Register word addresses.
    typedef enum logic [HIC_AW-1:0] {
        HIC_MASK  = 3'd0,
        HIC_MSET  = 3'd1,
        HIC_MCLR  = 3'd2,
        HIC_PEEK  = 3'd3,
        HIC_TAKE  = 3'd4,
        HIC_ACK   = 3'd5,
        HIC_CTRL  = 3'd6,
        HIC_SPARE = 3'd7
    } hic_reg_e;

    // Source slot assignments.
    localparam int SRC_RX_A     = 0;
    localparam int SRC_TX_DATA  = 1;
    localparam int SRC_TX_XFER  = 2;
    localparam int SRC_RX_B     = 3;
    localparam int SRC_RX_XFER  = 4;
    localparam int SRC_EVT_0    = 5;
    localparam int SRC_EVT_1    = 6;
    localparam int SRC_WAKE     = 7;
    localparam int SRC_TRACE_0  = 8;
    localparam int SRC_TRACE_1  = 9;
    localparam int SRC_CMD_DONE = 10;
    localparam int SRC_INIT_OK  = 14;

    // One strobe per register side effect.
    typedef struct packed {
        logic mask_wr;
        logic mask_set;
        logic mask_clr;
        logic ack_wr;
        logic ctrl_wr;
        logic take_rd;
        logic any_rd;
    } hic_strobe_t;

    function automatic hic_strobe_t hic_decode(input logic wr, input logic rd,
                                               input logic [HIC_AW-1:0] a);
        hic_strobe_t s;
        s = '0;
        if (wr) begin
            case (hic_reg_e'(a))
                HIC_MASK: s.mask_wr  = 1'b1;
                HIC_MSET: s.mask_set = 1'b1;
                HIC_MCLR: s.mask_clr = 1'b1;
                HIC_ACK:  s.ack_wr   = 1'b1;
                HIC_CTRL: s.ctrl_wr  = 1'b1;
                default:  ;
            endcase
        end
        if (rd) begin
            s.any_rd  = 1'b1;
            s.take_rd = (hic_reg_e'(a) == HIC_TAKE);
        end
        return s;
    endfunction

    // Interrupt line level from pending-and-unmasked state.
    function automatic logic hic_line(input logic pending, input logic en,
                                      input logic active_low);
        return (pending & en) ^ active_low;
    endfunction

endpackage

// File: rtl/hic_bus_decode.sv
module hic_bus_decode
    import hic_pkg::*;
(
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [HIC_AW-1:0] addr_i,
    output hic_strobe_t       strobe_o
);
    always_comb strobe_o = hic_decode(wr_i, rd_i, addr_i);
endmodule

// File: rtl/hic_mask_reg.sv
module hic_mask_reg
    import hic_pkg::*;
#(
    parameter int              NSRC     = 16,
    parameter logic [NSRC-1:0] MASK_RST = NSRC'(1)
) (
    input  logic            clk,
    input  logic            rst,
    input  hic_strobe_t     strobe_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] mask_o
);
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (strobe_i.mask_wr)
            mask_d = wdata_i;
        else if (strobe_i.mask_set)
            mask_d = mask_q | wdata_i;
        else if (strobe_i.mask_clr)
            mask_d = mask_q & ~wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= MASK_RST;
        else     mask_q <= mask_d;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/hic_status_reg.sv
module hic_status_reg
    import hic_pkg::*;
#(
    parameter int NSRC = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pulse_i,
    input  hic_strobe_t     strobe_i,
    input  logic [NSRC-1:0] ack_bits_i,
    output logic [NSRC-1:0] status_o
);
    logic [NSRC-1:0] clr_bits;
    logic [NSRC-1:0] status_q;

    always_comb begin
        clr_bits = '0;
        if (strobe_i.ack_wr)  clr_bits = ack_bits_i;
        if (strobe_i.take_rd) clr_bits = '1;
    end

    // Per bit: a new pulse takes priority over any clear in the same cycle.
    for (genvar b = 0; b < NSRC; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                status_q[b] <= 1'b0;
            else if (pulse_i[b])
                status_q[b] <= 1'b1;
            else if (clr_bits[b])
                status_q[b] <= 1'b0;
        end
    end

    assign status_o = status_q;
endmodule

// File: rtl/hic_read_mux.sv
module hic_read_mux
    import hic_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int DW   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  hic_strobe_t       strobe_i,
    input  logic [HIC_AW-1:0] addr_i,
    input  logic [NSRC-1:0]   mask_i,
    input  logic [NSRC-1:0]   status_i,
    input  logic              enable_i,
    output logic [DW-1:0]     rdata_o
);
    localparam int PAD = DW - NSRC;

    logic [DW-1:0] mask_ext;
    logic [DW-1:0] status_ext;
    logic [DW-1:0] sel;
    logic [DW-1:0] rdata_q;

    if (PAD > 0) begin : g_pad
        assign mask_ext   = {{PAD{1'b0}}, mask_i};
        assign status_ext = {{PAD{1'b0}}, status_i};
    end else begin : g_nopad
        assign mask_ext   = mask_i;
        assign status_ext = status_i;
    end

    always_comb begin
        case (hic_reg_e'(addr_i))
            HIC_MASK:           sel = mask_ext;
            HIC_PEEK, HIC_TAKE: sel = status_ext;
            HIC_CTRL:           sel = DW'(enable_i);
            default:            sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                  rdata_q <= '0;
        else if (strobe_i.any_rd) rdata_q <= sel;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/hic_top.sv
module hic_top
    import hic_pkg::*;
#(
    parameter int              NSRC     = 16,
    parameter int              DW       = 32,
    parameter logic [NSRC-1:0] MASK_RST = NSRC'(1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_pulse_i,
    input  logic [HIC_AW-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    input  logic              bus_rd_i,
    output logic [DW-1:0]     bus_rdata_o,
    input  logic              cfg_active_low_i,
    output logic              host_irq_o
);
    hic_strobe_t     strobe;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] status_q;
    logic            ctrl_en_q;
    logic [NSRC-1:0] wbits;

    assign wbits = bus_wdata_i[NSRC-1:0];

    hic_bus_decode u_dec (
        .wr_i     (bus_wr_i),
        .rd_i     (bus_rd_i),
        .addr_i   (bus_addr_i),
        .strobe_o (strobe)
    );

    hic_mask_reg #(.NSRC(NSRC), .MASK_RST(MASK_RST)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe),
        .wdata_i  (wbits),
        .mask_o   (mask_q)
    );

    hic_status_reg #(.NSRC(NSRC)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .pulse_i    (src_pulse_i),
        .strobe_i   (strobe),
        .ack_bits_i (wbits),
        .status_o   (status_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                 ctrl_en_q <= 1'b0;
        else if (strobe.ctrl_wr) ctrl_en_q <= bus_wdata_i[0];
    end

    hic_read_mux #(.NSRC(NSRC), .DW(DW)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe),
        .addr_i   (bus_addr_i),
        .mask_i   (mask_q),
        .status_i (status_q),
        .enable_i (ctrl_en_q),
        .rdata_o  (bus_rdata_o)
    );

    assign host_irq_o = hic_line(|(status_q & ~mask_q), ctrl_en_q, cfg_active_low_i);
endmodule

// File: rtl/hic_checker.sv
module hic_checker
    import hic_pkg::*;
#(
    parameter int              NSRC     = 16,
    parameter int              DW       = 32,
    parameter logic [NSRC-1:0] MASK_RST = NSRC'(1)
) (
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   src_pulse_i,
    input logic [HIC_AW-1:0] bus_addr_i,
    input logic              bus_wr_i,
    input logic [DW-1:0]     bus_wdata_i,
    input logic              bus_rd_i,
    input logic [DW-1:0]     bus_rdata_o,
    input logic              cfg_active_low_i,
    input logic              host_irq_o,
    input logic [NSRC-1:0]   mask_q,
    input logic [NSRC-1:0]   status_q,
    input logic              ctrl_en_q
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask_q == MASK_RST && status_q == '0 && !ctrl_en_q));

    assert_mask_load_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && bus_addr_i == HIC_MASK) |=> mask_q == $past(bus_wdata_i[NSRC-1:0]));

    assert_mask_set_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && bus_addr_i == HIC_MSET)
        |=> mask_q == ($past(mask_q) | $past(bus_wdata_i[NSRC-1:0])));

    assert_mask_clr_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && bus_addr_i == HIC_MCLR)
        |=> mask_q == ($past(mask_q) & ~$past(bus_wdata_i[NSRC-1:0])));

    assert_peek_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && bus_addr_i == HIC_PEEK && !bus_wr_i && src_pulse_i == '0)
        |=> $stable(status_q));

    assert_take_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && bus_addr_i == HIC_TAKE)
        |=> (status_q & ~$past(src_pulse_i)) == '0);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && bus_addr_i == HIC_ACK)
        |=> (status_q & $past(bus_wdata_i[NSRC-1:0]) & ~$past(src_pulse_i)) == '0);

    assert_pulse_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (|src_pulse_i) |=> (status_q & $past(src_pulse_i)) == $past(src_pulse_i));

    assert_idle_line_R9: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en_q |-> host_irq_o == cfg_active_low_i);

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~mask_q) == '0) |-> host_irq_o == cfg_active_low_i);

    assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && bus_addr_i == HIC_PEEK) |=> bus_rdata_o[NSRC-1:0] == $past(status_q));
endmodule

bind hic_top hic_checker #(.NSRC(NSRC), .DW(DW), .MASK_RST(MASK_RST)) u_hic_chk (
    .clk              (clk),
    .rst              (rst),
    .src_pulse_i      (src_pulse_i),
    .bus_addr_i       (bus_addr_i),
    .bus_wr_i         (bus_wr_i),
    .bus_wdata_i      (bus_wdata_i),
    .bus_rd_i         (bus_rd_i),
    .bus_rdata_o      (bus_rdata_o),
    .cfg_active_low_i (cfg_active_low_i),
    .host_irq_o       (host_irq_o),
    .mask_q           (mask_q),
    .status_q         (status_q),
    .ctrl_en_q        (ctrl_en_q)
);

// File: tb/hic_top_bench.sv
`timescale 1ns/1ps
module hic_top_bench;
    localparam int NSRC = 16;
    localparam int DW   = 32;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [2:0]  addr;
        logic [15:0] data;
        logic [15:0] pulse;
        logic        chk;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    // Each row is driven in one cycle; when chk is set, read data is checked after that edge.
    localparam vec_t [0:NV-1] TBL = '{
        '{1'b0,1'b1,3'd0,16'h0000,16'h0000,1'b1,16'h0001,4'd1},  // R1 mask reset value
        '{1'b0,1'b1,3'd3,16'h0000,16'h0000,1'b1,16'h0000,4'd1},  // R1 status empty
        '{1'b0,1'b1,3'd6,16'h0000,16'h0000,1'b1,16'h0000,4'd1},  // R1 enable off
        '{1'b1,1'b0,3'd0,16'h00F0,16'h0000,1'b0,16'h0000,4'd2},
        '{1'b0,1'b1,3'd0,16'h0000,16'h0000,1'b1,16'h00F0,4'd2},  // R2 direct load
        '{1'b1,1'b0,3'd1,16'h0003,16'h0000,1'b0,16'h0000,4'd3},
        '{1'b0,1'b1,3'd0,16'h0000,16'h0000,1'b1,16'h00F3,4'd3},  // R3 set alias
        '{1'b1,1'b0,3'd2,16'h0030,16'h0000,1'b0,16'h0000,4'd4},
        '{1'b0,1'b1,3'd0,16'h0000,16'h0000,1'b1,16'h00C3,4'd4},  // R4 clear alias
        '{1'b0,1'b0,3'd0,16'h0000,16'h0402,1'b0,16'h0000,4'd5},
        '{1'b0,1'b1,3'd3,16'h0000,16'h0000,1'b1,16'h0402,4'd5},  // R5 pulses latched
        '{1'b0,1'b1,3'd3,16'h0000,16'h0000,1'b1,16'h0402,4'd5},  // R5 peek kept status
        '{1'b1,1'b0,3'd5,16'h0002,16'h0000,1'b0,16'h0000,4'd7},
        '{1'b0,1'b1,3'd3,16'h0000,16'h0000,1'b1,16'h0400,4'd7},  // R7 ack one bit
        '{1'b0,1'b0,3'd0,16'h0000,16'h4001,1'b0,16'h0000,4'd6},
        '{1'b0,1'b1,3'd4,16'h0000,16'h0000,1'b1,16'h4401,4'd6},  // R6 take returns old
        '{1'b0,1'b1,3'd3,16'h0000,16'h0000,1'b1,16'h0000,4'd6},  // R6 all cleared
        '{1'b0,1'b0,3'd0,16'h0000,16'h0010,1'b0,16'h0000,4'd12},
        '{1'b1,1'b0,3'd3,16'hFFFF,16'h0000,1'b0,16'h0000,4'd12},
        '{1'b1,1'b0,3'd4,16'hFFFF,16'h0000,1'b0,16'h0000,4'd12},
        '{1'b0,1'b1,3'd3,16'h0000,16'h0000,1'b1,16'h0010,4'd12}, // R12 writes ignored
        '{1'b1,1'b0,3'd5,16'h0000,16'h0000,1'b0,16'h0000,4'd7},
        '{1'b0,1'b1,3'd3,16'h0000,16'h0000,1'b1,16'h0010,4'd7},  // R7 zero ack no effect
        '{1'b0,1'b1,3'd4,16'h0000,16'h0100,1'b1,16'h0010,4'd8},  // R8 take with pulse
        '{1'b0,1'b1,3'd3,16'h0000,16'h0000,1'b1,16'h0100,4'd8},  // R8 pulse survived
        '{1'b1,1'b0,3'd5,16'h0100,16'h0100,1'b0,16'h0000,4'd8},
        '{1'b0,1'b1,3'd3,16'h0000,16'h0000,1'b1,16'h0100,4'd8},  // R8 ack lost to pulse
        '{1'b0,1'b1,3'd7,16'h0000,16'h0000,1'b1,16'h0000,4'd11}, // R11 spare reads 0
        '{1'b0,1'b1,3'd1,16'h0000,16'h0000,1'b1,16'h0000,4'd11}, // R11 alias reads 0
        '{1'b0,1'b1,3'd5,16'h0000,16'h0000,1'b1,16'h0000,4'd11}  // R11 ack reads 0
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_pulse = '0;
    logic [2:0]      addr = '0;
    logic            wr = 1'b0;
    logic [DW-1:0]   wdata = '0;
    logic            rd = 1'b0;
    logic [DW-1:0]   rdata;
    logic            act_low = 1'b0;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hic_top u_hic_top (
        .clk              (clk),
        .rst              (rst),
        .src_pulse_i      (src_pulse),
        .bus_addr_i       (addr),
        .bus_wr_i         (wr),
        .bus_wdata_i      (wdata),
        .bus_rd_i         (rd),
        .bus_rdata_o      (rdata),
        .cfg_active_low_i (act_low),
        .host_irq_o       (irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then sample 1 ns after the rising edge.
    task automatic cyc(input logic w, input logic r, input logic [2:0] a,
                       input logic [15:0] d, input logic [15:0] p);
        @(negedge clk);
        wr = w; rd = r; addr = a; wdata = DW'(d); src_pulse = p;
        @(posedge clk);
        #1;
        wr = 1'b0; rd = 1'b0; src_pulse = '0;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 3'd0, 16'h0, 16'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0;
        check("R1", DW'(irq), DW'(0));         // R1 line idle after reset
        check("R1", rdata, DW'(0));

        for (int i = 0; i < NV; i++) begin
            cyc(TBL[i].wr, TBL[i].rd, TBL[i].addr, TBL[i].data, TBL[i].pulse);
            if (TBL[i].chk)
                check($sformatf("R%0d", TBL[i].req), rdata, DW'(TBL[i].exp));
        end

        // Clear pending state; mask is now 0x00C3.
        cyc(1'b1, 1'b0, 3'd5, 16'hFFFF, 16'h0);
        cyc(1'b0, 1'b0, 3'd0, 16'h0, 16'h0004);   // unmasked pulse, enable still off
        check("R9", DW'(irq), DW'(0));            // R9 gated by enable
        cyc(1'b1, 1'b0, 3'd5, 16'h0004, 16'h0);
        cyc(1'b1, 1'b0, 3'd6, 16'h0001, 16'h0);   // enable on
        check("R9", DW'(irq), DW'(0));
        cyc(1'b0, 1'b0, 3'd0, 16'h0, 16'h0001);   // masked source 0
        check("R9", DW'(irq), DW'(0));            // R9 mask blocks
        cyc(1'b0, 1'b0, 3'd0, 16'h0, 16'h0004);   // unmasked source 2
        check("R9", DW'(irq), DW'(1));            // R9 asserted same edge
        act_low = 1'b1;
        #1;
        check("R10", DW'(irq), DW'(0));           // R10 active low asserted
        cyc(1'b1, 1'b0, 3'd5, 16'hFFFF, 16'h0);
        check("R10", DW'(irq), DW'(1));           // R10 idles high
        act_low = 1'b0;
        #1;
        check("R10", DW'(irq), DW'(0));
        cyc(1'b0, 1'b0, 3'd0, 16'h0, 16'h0004);
        cyc(1'b1, 1'b0, 3'd2, 16'h0001, 16'h0);  // unmask source 0 while source 2 pending
        check("R9", DW'(irq), DW'(1));
        cyc(1'b1, 1'b0, 3'd1, 16'h0004, 16'h0);  // mask source 2 via set alias
        check("R9", DW'(irq), DW'(0));           // R9 masked after set alias

        // R11 read data holds between reads.
        cyc(1'b0, 1'b1, 3'd0, 16'h0, 16'h0);
        check("R11", rdata, DW'(16'h00C6));
        idle();
        cyc(1'b1, 1'b0, 3'd0, 16'h1234, 16'h0);
        check("R11", rdata, DW'(16'h00C6));

        // Mid-run reset returns every register to its reset value (R1).
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cyc(1'b0, 1'b1, 3'd0, 16'h0, 16'h0);
        check("R1", rdata, DW'(16'h0001));
        cyc(1'b0, 1'b1, 3'd3, 16'h0, 16'h0);
        check("R1", rdata, DW'(0));
        check("R1", DW'(irq), DW'(0));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule